// File: doc/BRIEF.md
# Conversion Result Post-Processor

This block sits directly behind a sigma-delta decimation filter that delivers signed 16-bit conversion results with a one-cycle valid strobe. After every restart of the filter, it drops the results the filter produces before it has settled. The number dropped depends on whether chopping is active. Every result after that counts as accepted. An accepted result advances a conversion counter, can be summed into a wide running total, and is tested against a magnitude threshold. The counter and the threshold test each raise their own sticky interrupt.

Alongside this accepted path, a fast overrange flag watches every raw strobe, including those dropped during settling. It reacts in the same cycle that a full-scale code appears. The configuration (enables, count limit, threshold) arrives as plain register-style inputs. Each flag has its own one-cycle clear input.

Top module: `adcpp_top`

## Requirements
- R1: After a restart or reset, the first two strobes are dropped when `chop_on` is 0 and the first strobe is dropped when `chop_on` is 1; dropped strobes change neither `acc_value`, `conv_count` nor `thr_irq`.
- R2: With `cfg_acc_en` high, `acc_value` equals its previous value plus the sign-extended result one clock after each accepted strobe; with `cfg_acc_en` low, accepted strobes leave `acc_value` unchanged.
- R3: On signed overflow of the 32-bit sum, `acc_value` saturates at 0x7FFFFFFF (positive) or 0x80000000 (negative) and the sticky `acc_ovf` flag sets one clock later.
- R4: `conv_count` rises by one per accepted strobe. When it reaches a nonzero `cfg_cnt_limit`, it returns to 0 and `cnt_irq` sets. A limit of 0 never sets `cnt_irq`, and the count then wraps modulo 65536.
- R5: With `cfg_thr_en` high, `thr_irq` sets one clock after an accepted result whose two's-complement magnitude is strictly greater than the unsigned 15-bit `cfg_thresh`. This applies to both polarities, and 0x8000 has magnitude 32768.
- R6: With `cfg_ovr_en` high, `ovr_flag` is high in the same cycle as any strobe carrying 0x7FFF or 0x8000, settled or not, and stays set afterwards. With `cfg_ovr_en` low, such strobes do not raise it.
- R7: Every flag is sticky until a one-cycle pulse on its own clear input. A setting event in the same cycle as the clear wins, and the flag stays set.
- R8: A `restart` pulse zeroes `acc_value`, `conv_count` and the settling state by the next clock. It leaves the flags and the configuration untouched.
- R9: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Filter restart pulse |
| chop_on | input | 1 | Chop mode active, shortens settling |
| res_valid | input | 1 | Result strobe |
| res_data | input | 16 | Two's-complement conversion result |
| cfg_acc_en | input | 1 | Accumulation enable |
| cfg_thr_en | input | 1 | Threshold interrupt enable |
| cfg_ovr_en | input | 1 | Fast overrange enable |
| cfg_cnt_limit | input | 16 | Conversions per count interrupt, 0 disables |
| cfg_thresh | input | 15 | Unsigned magnitude threshold |
| clr_cnt_irq | input | 1 | Clear count interrupt |
| clr_thr_irq | input | 1 | Clear threshold interrupt |
| clr_ovr | input | 1 | Clear overrange flag |
| clr_acc_ovf | input | 1 | Clear accumulator overflow flag |
| acc_value | output | 32 | Running sum |
| conv_count | output | 16 | Accepted conversions since wrap or restart |
| cnt_irq | output | 1 | Count interrupt, sticky |
| thr_irq | output | 1 | Threshold interrupt, sticky |
| ovr_flag | output | 1 | Fast overrange, sticky |
| acc_ovf | output | 1 | Accumulator overflow, sticky |

## Verification
Accumulator saturation is the hardest situation to bring about from the ports. A 16-bit input needs tens of thousands of accepted results before the 32-bit sum overflows. The stimulus holds the strobe high on every clock with the full-scale positive code for 65,541 cycles. With chopping off, two of these strobes are dropped, so 65,538 additions end exactly one count below the limit and the next addition must clip. That same run also shows the count wrapping with a zero limit and no count interrupt. Dropping during settling and the clear-versus-set collisions are handled with short directed sequences around `restart`.

// File: rtl/adcpp_pkg.sv
`timescale 1ns/1ps
package adcpp_pkg;
   localparam int FLG_CNT = 0;
   localparam int FLG_THR = 1;
   localparam int FLG_OVR = 2;
   localparam int FLG_ACC = 3;
   localparam int NUM_FLG = 4;
   typedef logic [NUM_FLG-1:0] flag_vec_t;
endpackage

// File: rtl/adcpp_settle.sv
`timescale 1ns/1ps
module adcpp_settle #(
   parameter int NOCHOP_SKIP = 2,
   parameter int CHOP_SKIP   = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic chop,
   input  logic valid,
   output logic accept
);
   localparam int MAX_SKIP = (NOCHOP_SKIP > CHOP_SKIP) ? NOCHOP_SKIP : CHOP_SKIP;
   localparam int SW       = $clog2(MAX_SKIP + 1);

   if (MAX_SKIP < 1 || CHOP_SKIP < 0 || NOCHOP_SKIP < 0) begin : g_bad_skip
      $error("adcpp_settle: skip counts must be non-negative with at least one nonzero");
   end

   logic [SW-1:0] seen;
   logic [SW-1:0] need;

   assign need   = chop ? SW'(CHOP_SKIP) : SW'(NOCHOP_SKIP);
   assign accept = valid && !restart && (seen >= need);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    seen <= '0;
      else if (restart)              seen <= '0;
      else if (valid && seen < need) seen <= seen + 1'b1;
   end

   AST_SETTLE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> !accept); // R1
endmodule

// File: rtl/adcpp_accum.sv
`timescale 1ns/1ps
module adcpp_accum #(
   parameter int DATA_W   = 16,
   parameter int ACC_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              take,
   input  logic              enable,
   input  logic [DATA_W-1:0] din,
   output logic [ACC_W-1:0]  acc,
   output logic              ovf_evt
);
   localparam int EXT_W = ACC_W - DATA_W;
   localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
   localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

   if (EXT_W < 1) begin : g_bad_width
      $error("adcpp_accum: accumulator must be wider than the data");
   end

   logic [ACC_W-1:0] ext;
   logic [ACC_W-1:0] raw;
   logic [ACC_W-1:0] nxt;
   logic             wrap;

   assign ext  = {{EXT_W{din[DATA_W-1]}}, din};
   assign raw  = acc + ext;
   assign wrap = (acc[ACC_W-1] == ext[ACC_W-1]) && (raw[ACC_W-1] != acc[ACC_W-1]);

   if (SATURATE) begin : g_sat
      assign nxt = wrap ? (acc[ACC_W-1] ? ACC_MIN : ACC_MAX) : raw;
      AST_ACC_CLIPPED: assert property (@(posedge clk) disable iff (!rst_n)
         ovf_evt |=> (acc == ACC_MAX || acc == ACC_MIN)); // R3
   end else begin : g_wrap
      assign nxt = raw;
   end

   assign ovf_evt = take && enable && wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                acc <= '0;
      else if (restart)          acc <= '0;
      else if (take && enable)   acc <= nxt;
   end

   AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !(take && enable)) |=> $stable(acc)); // R2
endmodule

// File: rtl/adcpp_counter.sv
`timescale 1ns/1ps
module adcpp_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             take,
   input  logic [CNT_W-1:0] limit,
   output logic [CNT_W-1:0] count,
   output logic             hit_evt
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("adcpp_counter: counter width must be positive");
   end

   logic [CNT_W-1:0] inc;

   assign inc     = count + 1'b1;
   assign hit_evt = take && (limit != '0) && (inc == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        count <= '0;
      else if (restart)  count <= '0;
      else if (take)     count <= hit_evt ? '0 : inc;
   end

   AST_CNT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      hit_evt |=> (count == '0)); // R4
   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!take && !restart) |=> $stable(count)); // R4
endmodule

// File: rtl/adcpp_thresh.sv
`timescale 1ns/1ps
module adcpp_thresh #(
   parameter int DATA_W = 16
) (
   input  logic [DATA_W-1:0] din,
   input  logic [DATA_W-2:0] thresh,
   output logic              exceed,
   output logic              full
);
   localparam logic [DATA_W-1:0] POS_FS = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] NEG_FS = {1'b1, {(DATA_W-1){1'b0}}};

   if (DATA_W < 2) begin : g_bad_data
      $error("adcpp_thresh: data width must be at least 2");
   end

   logic [DATA_W-1:0] mag;

   assign mag    = din[DATA_W-1] ? (~din + 1'b1) : din;
   assign exceed = mag > {1'b0, thresh};
   assign full   = (din == POS_FS) || (din == NEG_FS);
endmodule

// File: rtl/adcpp_flags.sv
`timescale 1ns/1ps
module adcpp_flags
   import adcpp_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  flag_vec_t set,
   input  flag_vec_t clr,
   output flag_vec_t q
);
   for (genvar i = 0; i < NUM_FLG; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      q[i] <= 1'b0;
         else if (set[i]) q[i] <= 1'b1;
         else if (clr[i]) q[i] <= 1'b0;
      end

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (q[i] && !clr[i]) |=> q[i]); // R7
      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
         set[i] |=> q[i]); // R7
   end
endmodule

// File: rtl/adcpp_top.sv
`timescale 1ns/1ps
module adcpp_top
   import adcpp_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ACC_W       = 32,
   parameter int CNT_W       = 16,
   parameter int NOCHOP_SKIP = 2,
   parameter int CHOP_SKIP   = 1,
   parameter bit SATURATE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              chop_on,
   input  logic              res_valid,
   input  logic [DATA_W-1:0] res_data,
   input  logic              cfg_acc_en,
   input  logic              cfg_thr_en,
   input  logic              cfg_ovr_en,
   input  logic [CNT_W-1:0]  cfg_cnt_limit,
   input  logic [DATA_W-2:0] cfg_thresh,
   input  logic              clr_cnt_irq,
   input  logic              clr_thr_irq,
   input  logic              clr_ovr,
   input  logic              clr_acc_ovf,
   output logic [ACC_W-1:0]  acc_value,
   output logic [CNT_W-1:0]  conv_count,
   output logic              cnt_irq,
   output logic              thr_irq,
   output logic              ovr_flag,
   output logic              acc_ovf
);
   logic      accept;
   logic      exceed;
   logic      full;
   logic      hit_evt;
   logic      ovf_evt;
   flag_vec_t set_vec;
   flag_vec_t clr_vec;
   flag_vec_t flag_q;

   adcpp_settle #(.NOCHOP_SKIP(NOCHOP_SKIP), .CHOP_SKIP(CHOP_SKIP)) u_settle (
      .clk(clk), .rst_n(rst_n), .restart(restart), .chop(chop_on),
      .valid(res_valid), .accept(accept));

   adcpp_thresh #(.DATA_W(DATA_W)) u_thresh (
      .din(res_data), .thresh(cfg_thresh), .exceed(exceed), .full(full));

   adcpp_counter #(.CNT_W(CNT_W)) u_counter (
      .clk(clk), .rst_n(rst_n), .restart(restart), .take(accept),
      .limit(cfg_cnt_limit), .count(conv_count), .hit_evt(hit_evt));

   adcpp_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W), .SATURATE(SATURATE)) u_accum (
      .clk(clk), .rst_n(rst_n), .restart(restart), .take(accept),
      .enable(cfg_acc_en), .din(res_data), .acc(acc_value), .ovf_evt(ovf_evt));

   always_comb begin
      set_vec          = '0;
      set_vec[FLG_CNT] = hit_evt;
      set_vec[FLG_THR] = accept && cfg_thr_en && exceed;
      set_vec[FLG_OVR] = res_valid && cfg_ovr_en && full;
      set_vec[FLG_ACC] = ovf_evt;
      clr_vec          = '0;
      clr_vec[FLG_CNT] = clr_cnt_irq;
      clr_vec[FLG_THR] = clr_thr_irq;
      clr_vec[FLG_OVR] = clr_ovr;
      clr_vec[FLG_ACC] = clr_acc_ovf;
   end

   adcpp_flags u_flags (.clk(clk), .rst_n(rst_n), .set(set_vec), .clr(clr_vec), .q(flag_q));

   assign cnt_irq  = flag_q[FLG_CNT];
   assign thr_irq  = flag_q[FLG_THR];
   assign acc_ovf  = flag_q[FLG_ACC];
   assign ovr_flag = flag_q[FLG_OVR] | set_vec[FLG_OVR];

   AST_OVR_SAME_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && cfg_ovr_en && res_data[DATA_W-1] == 1'b0 && &res_data[DATA_W-2:0])
      |-> ovr_flag); // R6
   AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (conv_count == '0 && acc_value == '0)); // R8
   AST_RESTART_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && cnt_irq && !clr_cnt_irq) |=> cnt_irq); // R8
endmodule

// File: tb/adcpp_top_bench.sv
`timescale 1ns/1ps
module adcpp_top_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        restart = 1'b0;
   logic        chop_on = 1'b0;
   logic        res_valid = 1'b0;
   logic [15:0] res_data = '0;
   logic        cfg_acc_en = 1'b0;
   logic        cfg_thr_en = 1'b0;
   logic        cfg_ovr_en = 1'b0;
   logic [15:0] cfg_cnt_limit = '0;
   logic [14:0] cfg_thresh = '0;
   logic        clr_cnt_irq = 1'b0;
   logic        clr_thr_irq = 1'b0;
   logic        clr_ovr = 1'b0;
   logic        clr_acc_ovf = 1'b0;
   logic [31:0] acc_value;
   logic [15:0] conv_count;
   logic        cnt_irq, thr_irq, ovr_flag, acc_ovf;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   adcpp_top u_adcpp_top (
      .clk(clk), .rst_n(rst_n), .restart(restart), .chop_on(chop_on),
      .res_valid(res_valid), .res_data(res_data), .cfg_acc_en(cfg_acc_en),
      .cfg_thr_en(cfg_thr_en), .cfg_ovr_en(cfg_ovr_en), .cfg_cnt_limit(cfg_cnt_limit),
      .cfg_thresh(cfg_thresh), .clr_cnt_irq(clr_cnt_irq), .clr_thr_irq(clr_thr_irq),
      .clr_ovr(clr_ovr), .clr_acc_ovf(clr_acc_ovf), .acc_value(acc_value),
      .conv_count(conv_count), .cnt_irq(cnt_irq), .thr_irq(thr_irq),
      .ovr_flag(ovr_flag), .acc_ovf(acc_ovf));

   // Table walked after a restart with chop off, limit 4, threshold 1000.
   localparam int NV = 6;
   localparam int VDAT[NV]  = '{100, 5000, 200, -300, 1000, -1001};
   localparam int VACC[NV]  = '{0, 0, 200, -100, 900, -101};
   localparam int VCNT[NV]  = '{0, 0, 1, 2, 3, 0};
   localparam int VCIRQ[NV] = '{0, 0, 0, 0, 0, 1};
   localparam int VTIRQ[NV] = '{0, 0, 0, 0, 0, 1};

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic strobe(input logic [15:0] d);
      @(negedge clk);
      res_valid = 1'b1;
      res_data  = d;
      @(negedge clk);
      res_valid = 1'b0;
   endtask

   task automatic pulse_restart();
      @(negedge clk);
      restart = 1'b1;
      @(negedge clk);
      restart = 1'b0;
   endtask

   task automatic clear_all();
      @(negedge clk);
      {clr_cnt_irq, clr_thr_irq, clr_ovr, clr_acc_ovf} = 4'hF;
      @(negedge clk);
      {clr_cnt_irq, clr_thr_irq, clr_ovr, clr_acc_ovf} = 4'h0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      chk("R9 acc", acc_value, 32'h0);
      chk("R9 count", 32'(conv_count), 32'h0);
      chk("R9 flags", {28'h0, cnt_irq, thr_irq, ovr_flag, acc_ovf}, 32'h0);

      // Table: R1 drop, R2 sum, R4 wrap, R5 threshold
      cfg_acc_en = 1'b1; cfg_thr_en = 1'b1; cfg_cnt_limit = 16'd4; cfg_thresh = 15'd1000;
      pulse_restart();
      for (int i = 0; i < NV; i++) begin
         strobe(16'(VDAT[i]));
         chk("R1/R2 acc", acc_value, 32'(VACC[i]));
         chk("R1/R4 count", 32'(conv_count), 32'(VCNT[i]));
         chk("R4 cnt_irq", 32'(cnt_irq), 32'(VCIRQ[i]));
         chk("R1/R5 thr_irq", 32'(thr_irq), 32'(VTIRQ[i]));
         chk("R6 ovr idle", 32'(ovr_flag), 32'h0);
      end

      // R8 restart clears count and sum but keeps flags
      pulse_restart();
      chk("R8 acc", acc_value, 32'h0);
      chk("R8 count", 32'(conv_count), 32'h0);
      chk("R8 cnt_irq kept", 32'(cnt_irq), 32'h1);
      chk("R8 thr_irq kept", 32'(thr_irq), 32'h1);

      // R1 chop on drops only one
      chop_on = 1'b1;
      strobe(16'd7);
      chk("R1 chop drop", acc_value, 32'h0);
      strobe(16'd9);
      chk("R1 chop accept acc", acc_value, 32'd9);
      chk("R1 chop accept count", 32'(conv_count), 32'd1);

      // R2 accumulation disabled
      cfg_acc_en = 1'b0;
      strobe(16'd50);
      chk("R2 acc disabled", acc_value, 32'd9);
      chk("R2 count still runs", 32'(conv_count), 32'd2);
      cfg_acc_en = 1'b1;

      // R5 both polarities, equality not exceeding; R7 clear
      clear_all();
      chk("R7 cleared", {28'h0, cnt_irq, thr_irq, ovr_flag, acc_ovf}, 32'h0);
      cfg_thresh = 15'h7FFF;
      strobe(16'h7FFF);
      chk("R5 equal no irq", 32'(thr_irq), 32'h0);
      chk("R6 disabled", 32'(ovr_flag), 32'h0);
      strobe(16'h8000);
      chk("R5 negative full scale", 32'(thr_irq), 32'h1);
      // R7 clear in same cycle as a new event keeps flag
      @(negedge clk);
      clr_thr_irq = 1'b1; res_valid = 1'b1; res_data = 16'h8000;
      @(negedge clk);
      clr_thr_irq = 1'b0; res_valid = 1'b0;
      chk("R7 set wins thr", 32'(thr_irq), 32'h1);
      clear_all();

      // R6 fast overrange during settling, same cycle
      cfg_ovr_en = 1'b1; cfg_thr_en = 1'b0; chop_on = 1'b0;
      pulse_restart();
      @(negedge clk);
      res_valid = 1'b1; res_data = 16'h8000;
      #1;
      chk("R6 same cycle", 32'(ovr_flag), 32'h1);
      @(negedge clk);
      res_valid = 1'b0;
      chk("R6 sticky", 32'(ovr_flag), 32'h1);
      chk("R1 unsettled acc", acc_value, 32'h0);
      @(negedge clk);
      clr_ovr = 1'b1;
      @(negedge clk);
      clr_ovr = 1'b0;
      chk("R7 ovr cleared", 32'(ovr_flag), 32'h0);
      @(negedge clk);
      clr_ovr = 1'b1; res_valid = 1'b1; res_data = 16'h7FFF;
      @(negedge clk);
      clr_ovr = 1'b0; res_valid = 1'b0;
      chk("R7 set wins ovr", 32'(ovr_flag), 32'h1);
      cfg_ovr_en = 1'b0;
      clear_all();

      // R3 positive saturation, R4 zero limit wraps without irq
      cfg_cnt_limit = 16'd0;
      pulse_restart();
      @(negedge clk);
      res_valid = 1'b1; res_data = 16'h7FFF;
      repeat (65541) @(negedge clk);
      res_valid = 1'b0;
      chk("R3 saturated", acc_value, 32'h7FFF_FFFF);
      chk("R3 ovf flag", 32'(acc_ovf), 32'h1);
      chk("R4 zero limit wrap", 32'(conv_count), 32'd3);
      chk("R4 zero limit no irq", 32'(cnt_irq), 32'h0);
      @(negedge clk);
      clr_acc_ovf = 1'b1;
      @(negedge clk);
      clr_acc_ovf = 1'b0;
      chk("R7 ovf cleared", 32'(acc_ovf), 32'h0);
      strobe(16'hFFFF);
      chk("R3 leaves clip", acc_value, 32'h7FFF_FFFE);
      chk("R3 no new ovf", 32'(acc_ovf), 32'h0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule